// File: doc/BRIEF.md
# Task Period and Deadline Timer Unit

This block keeps the time budget of one hardware thread context in a real-time scheduler; a chip instantiates one copy per task. It holds four down-counters. The first is a recurrence timer that marks the start of each task period. The second is a watchdog that software must restart before it runs out. The other two measure deadlines from the start of each period. The first deadline raises a soft alarm. The second raises a hard fault. Each expiry sets a sticky event flag, but only when that counter's enable bit is set. The scheduler reads the flags as event inputs: a period event makes a waiting task ready again, and a deadline or watchdog event reports an overrun.

Software writes the reload values, the enable bits and an arm bit through a write-only port made of an address, data and a strobe. Each write takes effect at the next clock edge. Flags stay set until software writes a one to the matching bit of the clear register. When a new period begins, the two deadline flags are cleared and the deadline counters start again.

Top module: `ttu_task_timers`

## Requirements
- R1: After reset, evt_o is 0, all reload values and control bits are 0, and the unit is disarmed.
- R2: A write with wr_en_i high takes effect at the next rising clock edge. The address map is: 0 = control (bit0 period enable, bit1 watchdog enable, bit2 soft-deadline enable, bit3 hard-deadline enable, bit4 arm), 1 = period reload, 2 = watchdog reload, 3 = soft-deadline reload, 4 = hard-deadline reload, 5 = flag clear, 6 = watchdog kick. A write to address 7 has no effect.
- R3: While arm is 0, every counter holds its reload value. With a reload of N, the period timer first expires N+1 edges after the edge that sets arm, and then every N+1 edges.
- R4: evt_o bit0 is the period event, bit1 the watchdog, bit2 the soft deadline and bit3 the hard deadline. A flag is set at an expiry edge only if its enable bit is 1, and each output bit equals its flag ANDed with its current enable bit.
- R5: A counter whose enable bit is 0 keeps counting. Enabling it later does not change its phase.
- R6: A flag stays set until a write of 1 to its bit at address 5. If an expiry and a clear hit the same bit at the same edge, the flag ends up set.
- R7: The watchdog reloads itself after each expiry. Any write to address 6 reloads it at that edge.
- R8: At every period expiry both deadline counters load their reload values and count from there. Each deadline expires at most once per period. A deadline expiry that falls on a period-expiry edge is cancelled, so a deadline longer than the period never fires.
- R9: At a period expiry, the soft and hard deadline flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Write data |
| evt_o | output | 4 | Gated event flags: period, watchdog, soft deadline, hard deadline |

## Verification
A counter that loses its count or its phase shows up as an event edge that comes early or late by at least one cycle. The bench therefore samples the cycle just before each predicted expiry as well as the expiry cycle itself. A deadline counter that fails to restart, or that is not limited to one firing per period, only becomes visible later in the period. It shows as a soft or hard bit appearing a full reload interval after the expected time, so those checks are placed after a flag has been cleared, where a second firing would be seen. Flag state that is gated wrongly or cleared wrongly appears on evt_o at the edge right after the write that caused it.

// File: rtl/ttu_pkg.sv
package ttu_pkg;
    localparam int unsigned NUM_EVT = 4;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned EV_PER  = 0;
    localparam int unsigned EV_WD   = 1;
    localparam int unsigned EV_SOFT = 2;
    localparam int unsigned EV_HARD = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_PER  = 3'd1,
        A_WD   = 3'd2,
        A_SOFT = 3'd3,
        A_HARD = 3'd4,
        A_CLR  = 3'd5,
        A_KICK = 3'd6
    } addr_e;

    typedef struct packed {
        logic               arm;
        logic [NUM_EVT-1:0] en;
    } ctrl_t;
endpackage

// File: rtl/ttu_regs.sv
module ttu_regs
    import ttu_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    output ctrl_t                           ctrl,
    output logic [NUM_EVT-1:0][CNT_W-1:0]   reload,
    output logic [NUM_EVT-1:0]              clr,
    output logic                            kick
);
    localparam int unsigned CTRL_W = NUM_EVT + 1;

    typedef struct packed {
        ctrl_t                          ctrl;
        logic [NUM_EVT-1:0][CNT_W-1:0]  rel;
    } reg_st_t;

    reg_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        clr  = '0;
        kick = 1'b0;
        if (wr_en) begin
            if (wr_addr == A_CTRL) s_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_addr == A_CLR)  clr      = wr_data[NUM_EVT-1:0];
            if (wr_addr == A_KICK) kick     = 1'b1;
            for (int i = 0; i < NUM_EVT; i++) begin
                if (wr_addr == ADDR_W'(i + 1)) s_d.rel[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl   = s_q.ctrl;
    assign reload = s_q.rel;

    // R2: a control write is visible after the next edge
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL) |=> ({ctrl.arm, ctrl.en} == $past(wr_data[CTRL_W-1:0])));
endmodule

// File: rtl/ttu_counter.sv
module ttu_counter #(
    parameter int unsigned CNT_W    = 32,
    parameter bit          ONE_SHOT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             spent;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = arm && !restart && !s_q.spent && (s_q.cnt == '0);
        if (!arm || restart) begin
            s_d.cnt   = reload;
            s_d.spent = 1'b0;
        end else if (expire) begin
            s_d.cnt   = reload;
            s_d.spent = ONE_SHOT;
        end else if (!s_q.spent) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a running, non-zero count drops by one per edge
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !restart && !s_q.spent && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R3: after an expiry the counter holds its reload value
    a_r3_reload_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (s_q.cnt == $past(reload)));

    // R8: a spent one-shot counter stays parked until restart or disarm
    a_r8_spent_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.spent && arm && !restart) |=> (s_q.spent && $stable(s_q.cnt)));
endmodule

// File: rtl/ttu_task_timers.sv
module ttu_task_timers
    import ttu_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_addr_i,
    input  logic [CNT_W-1:0]   wr_data_i,
    output logic [3:0]         evt_o
);
    localparam logic [NUM_EVT-1:0] DL_MASK =
        NUM_EVT'((1 << EV_SOFT) | (1 << EV_HARD));

    ctrl_t                          ctrl;
    logic [NUM_EVT-1:0][CNT_W-1:0]  reload;
    logic [NUM_EVT-1:0]             clr;
    logic                           kick;
    logic                           per_exp;
    logic [NUM_EVT-1:1]             exp_oth;
    logic [NUM_EVT-1:0]             exp_all;

    ttu_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .ctrl    (ctrl),
        .reload  (reload),
        .clr     (clr),
        .kick    (kick)
    );

    ttu_counter #(.CNT_W(CNT_W), .ONE_SHOT(1'b0)) u_per (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .arm     (ctrl.arm),
        .restart (1'b0),
        .reload  (reload[EV_PER]),
        .expire  (per_exp)
    );

    for (genvar g = 1; g < NUM_EVT; g++) begin : g_tmr
        logic restart;
        if (g == EV_WD) begin : g_wd
            assign restart = kick;
        end else begin : g_dl
            assign restart = per_exp;
        end
        ttu_counter #(.CNT_W(CNT_W), .ONE_SHOT(bit'(g != EV_WD))) u_cnt (
            .clk     (clk_i),
            .rst_n   (rst_ni),
            .arm     (ctrl.arm),
            .restart (restart),
            .reload  (reload[g]),
            .expire  (exp_oth[g])
        );
    end

    assign exp_all = {exp_oth, per_exp};

    typedef struct packed {
        logic [NUM_EVT-1:0] flag;
    } flag_st_t;

    flag_st_t f_d, f_q;

    always_comb begin
        logic [NUM_EVT-1:0] keep;
        keep = ~clr;
        if (per_exp) keep = keep & ~DL_MASK;
        f_d.flag = (f_q.flag & keep) | (exp_all & ctrl.en);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    assign evt_o = f_q.flag & ctrl.en;

    // R9: a new period leaves no deadline flag behind
    a_r9_deadline_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        per_exp |=> ((f_q.flag & DL_MASK) == '0));

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
        // R4: a flag only rises while its enable bit was set
        a_r4_flag_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(f_q.flag[i]) |-> $past(ctrl.en[i]));
        // R6: a clear without a coinciding expiry drops the flag
        a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr[i] && !exp_all[i]) |=> !f_q.flag[i]);
        // R6: an enabled expiry always leaves the flag set
        a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (exp_all[i] && ctrl.en[i]) |=> f_q.flag[i]);
    end
endmodule

// File: tb/ttu_task_timers_bench.sv
module ttu_task_timers_bench;
    localparam int CNT_W = 32;
    localparam logic [2:0] AD_CTRL = 3'd0, AD_PER = 3'd1, AD_WD = 3'd2,
                           AD_SOFT = 3'd3, AD_HARD = 3'd4, AD_CLR = 3'd5,
                           AD_KICK = 3'd6, AD_NONE = 3'd7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [3:0]       evt;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    int         q_at[$];
    logic [3:0] q_val[$];
    string      q_req[$];

    ttu_task_timers #(.CNT_W(CNT_W)) u_ttu_task_timers (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .evt_o     (evt)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // scoreboard monitor: compares queued expectations at their cycle
    always @(negedge clk) begin
        while (q_at.size() > 0 && q_at[0] <= cyc) begin
            int         at_v;
            logic [3:0] val_v;
            string      req_v;
            at_v  = q_at.pop_front();
            val_v = q_val.pop_front();
            req_v = q_req.pop_front();
            checks++;
            if (at_v < cyc) begin
                errors++;
                $display("FAIL %s slot %0d missed at cycle %0d actual=%b expected=%b",
                         req_v, at_v, cyc, evt, val_v);
            end else if (evt !== val_v) begin
                errors++;
                $display("FAIL %s cycle %0d actual=%b expected=%b", req_v, cyc, evt, val_v);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    task automatic expect_at(input int at, input logic [3:0] v, input string r);
        q_at.push_back(at);
        q_val.push_back(v);
        q_req.push_back(r);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d, output int t);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en = 1'b0;
        t = cyc;
    endtask

    task automatic wr_at(input int target, input logic [2:0] a, input logic [CNT_W-1:0] d);
        int t;
        while (cyc + 1 < target) step();
        wr(a, d, t);
    endtask

    task automatic drain();
        while (q_at.size() > 0) step();
        step();
    endtask

    initial begin
        int t, ta, tb, td, te;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        expect_at(cyc + 1, 4'h0, "R1");
        drain();

        // R2: address 7 is ignored (would arm with all enables and zero reloads if aliased)
        wr(AD_NONE, 'h1F, t);
        expect_at(t + 1, 4'h0, "R2");
        expect_at(t + 2, 4'h0, "R2");
        drain();

        // Period timer, sticky flag, clear and set-wins
        wr(AD_PER, 4, t);
        wr(AD_CTRL, 'h11, ta);
        expect_at(ta + 4,  4'h0, "R3");
        expect_at(ta + 5,  4'h1, "R3");
        expect_at(ta + 6,  4'h1, "R6");
        expect_at(ta + 7,  4'h0, "R6");
        expect_at(ta + 9,  4'h0, "R3");
        expect_at(ta + 10, 4'h1, "R3");
        expect_at(ta + 15, 4'h1, "R6");
        wr_at(ta + 7,  AD_CLR, 1);
        wr_at(ta + 15, AD_CLR, 1);
        drain();

        // Watchdog: disabled counting keeps phase, kick restarts
        wr(AD_CTRL, 0, t);
        wr(AD_CLR, 'hF, t);
        wr(AD_PER, 100, t);
        wr(AD_WD, 2, t);
        wr(AD_CTRL, 'h10, tb);
        expect_at(tb + 3,  4'h0, "R5");
        expect_at(tb + 6,  4'h0, "R5");
        expect_at(tb + 8,  4'h0, "R5");
        expect_at(tb + 9,  4'h2, "R5");
        expect_at(tb + 10, 4'h0, "R6");
        expect_at(tb + 12, 4'h0, "R7");
        expect_at(tb + 13, 4'h0, "R7");
        expect_at(tb + 14, 4'h2, "R7");
        wr_at(tb + 7,  AD_CTRL, 'h12);
        wr_at(tb + 10, AD_CLR, 2);
        wr_at(tb + 11, AD_KICK, 0);
        drain();

        // Deadlines within a period of 10 edges
        wr(AD_CTRL, 0, t);
        wr(AD_CLR, 'hF, t);
        wr(AD_PER, 9, t);
        wr(AD_SOFT, 3, t);
        wr(AD_HARD, 6, t);
        wr(AD_CTRL, 'h1D, td);
        expect_at(td + 3,  4'h0, "R8");
        expect_at(td + 4,  4'h4, "R8");
        expect_at(td + 6,  4'h4, "R8");
        expect_at(td + 7,  4'hC, "R8");
        expect_at(td + 9,  4'hC, "R6");
        expect_at(td + 10, 4'h1, "R9");
        expect_at(td + 13, 4'h1, "R8");
        expect_at(td + 14, 4'h5, "R8");
        expect_at(td + 15, 4'h1, "R6");
        expect_at(td + 17, 4'h9, "R8");
        expect_at(td + 19, 4'h9, "R8");
        expect_at(td + 20, 4'h1, "R9");
        wr_at(td + 15, AD_CLR, 4);
        drain();

        // Hard deadline longer than the period never fires; output masking
        wr(AD_CTRL, 0, t);
        wr(AD_CLR, 'hF, t);
        wr(AD_PER, 4, t);
        wr(AD_HARD, 7, t);
        wr(AD_CTRL, 'h19, te);
        expect_at(te + 5,  4'h1, "R8");
        expect_at(te + 9,  4'h1, "R8");
        expect_at(te + 14, 4'h1, "R8");
        expect_at(te + 16, 4'h0, "R4");
        expect_at(te + 17, 4'h1, "R4");
        wr_at(te + 16, AD_CTRL, 'h10);
        wr_at(te + 17, AD_CTRL, 'h11);
        drain();

        finish_run();
    end
endmodule